// File: doc/BRIEF.md
# Picture-in-Picture Inset Compositor

The block shrinks a digitized sub-picture and lays it over the main picture at a programmable position. On the capture side it receives luma and two colour-difference samples (blue and red difference, offset binary, 128 meaning zero) one per clock whenever `cap_valid` is high. It keeps every third or every fourth input line and every third or every fourth sample, depending on the size mode. It cuts each kept sample to 7 bits and writes it into an internal field buffer with separate read and write ports. Colour difference is stored at one quarter of the luma rate.

On the display side the block counts main-picture samples and lines. Inside the inset rectangle it replaces the main picture with the stored samples. Around the rectangle it can draw a one-pixel border at a programmable luma level. Everywhere else it passes the main picture through. Position, size mode and border settings are taken from the configuration inputs only on a main-picture vertical sync, so a frame never shows a half-applied change. The enable and freeze controls act at once.

The default parameters give a small buffer: 21 luma columns, 5 chroma columns, and 7 or 5 rows. A full-size instance sets 229 luma columns, 57 chroma columns, 69 rows for the one-third size and 52 rows for the one-quarter size.

Top module: `pip_inset_compositor`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, `out_valid` is 0 and `out_y`, `out_cb` and `out_cr` are 0.
- R2: With `cfg_enable` low, every valid main sample appears unchanged on the three outputs one clock after it is presented, with `out_valid` high.
- R3: Main samples outside the inset window and outside the drawn border pass through unchanged. This includes the border ring while the border is disabled.
- R4: Size mode 0 (one-third) keeps input lines 0, 3, 6, … counted from `cap_vsync`, and valid samples 0, 3, 6, … counted from the line start. It shows LUMA_PIX columns by ROWS_NINTH rows. Stored row r and column x come from input line 3r and sample 3x.
- R5: Size mode 1 (one-quarter) keeps every fourth line and every fourth valid sample, and shows LUMA_PIX columns by ROWS_SIXTEENTH rows.
- R6: Every stored sample keeps the 7 most significant bits of its 8-bit input. It is shown as those bits with a 0 least significant bit, so a displayed inset sample equals the input sample AND 0xFE.
- R7: Colour difference is stored for stored luma columns 0, 4, 8, …. Display column x shows chroma entry min(floor(x/4), CHROMA_PIX-1) of its row.
- R8: Horizontal position counts valid main samples since the last `disp_hsync` or `disp_vsync`. Vertical position counts lines, where line 0 follows `disp_vsync` and each `disp_hsync` starts the next line. The inset's top-left stored sample appears at (`cfg_pos_x`, `cfg_pos_y`).
- R9: With the border enabled, the positions one column left and right of the window and one line above and below it (corners included) show luma `cfg_border_lvl` and both colour differences at 128.
- R10: While `cfg_freeze` is high, nothing is written to the buffer, and the display keeps showing the previously stored field.
- R11: Position, size mode, border enable and border level change only on `disp_vsync`. A change applied after a vertical sync does not affect the rest of that frame.
- R12: Capture counts samples only on `cap_valid`. Input lines beyond the last stored row and samples beyond the last stored column never overwrite stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by capture and display |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Overlay on; when low the main picture passes through |
| cfg_freeze | input | 1 | Suppress all buffer writes |
| cfg_size | input | 1 | 0: one-third size, 1: one-quarter size |
| cfg_border_en | input | 1 | Draw the border ring |
| cfg_border_lvl | input | 8 | Border luma level |
| cfg_pos_x | input | 10 | Inset left column in main samples |
| cfg_pos_y | input | 10 | Inset top line in main lines |
| cap_valid | input | 1 | Capture sample strobe |
| cap_hsync | input | 1 | Capture line start pulse (not with cap_valid) |
| cap_vsync | input | 1 | Capture field start pulse (not with cap_valid) |
| cap_y | input | 8 | Sub-picture luma |
| cap_cb | input | 8 | Sub-picture blue difference |
| cap_cr | input | 8 | Sub-picture red difference |
| disp_valid | input | 1 | Main sample strobe |
| disp_hsync | input | 1 | Main line start pulse (not with disp_valid) |
| disp_vsync | input | 1 | Main field start pulse, loads settings |
| main_y | input | 8 | Main luma |
| main_cb | input | 8 | Main blue difference |
| main_cr | input | 8 | Main red difference |
| out_valid | output | 1 | Output sample strobe, one clock after disp_valid |
| out_y | output | 8 | Composited luma |
| out_cb | output | 8 | Composited blue difference |
| out_cr | output | 8 | Composited red difference |

## Verification
The assertions assume that sync pulses never coincide with a valid sample on the same side, and that the capture side never changes size mode in the middle of a field. The bench drives each sync as a one-cycle pulse with its valid strobe low. It captures only after the display vertical sync that loads a new size. It sweeps every position of a 40 by 16 main frame in each phase. Capture lines carry periodic idle cycles and run past the last stored row and column, which exercises the counting rules.

// File: rtl/pip_pkg.sv
`timescale 1ns/1ps
package pip_pkg;
  typedef enum logic {
    SZ_THIRD   = 1'b0,
    SZ_QUARTER = 1'b1
  } pip_size_e;

  // decimation step minus one for a size mode
  function automatic logic [1:0] step_m1(input pip_size_e sz);
    return (sz == SZ_QUARTER) ? 2'd3 : 2'd2;
  endfunction
endpackage

// File: rtl/pip_capture_wr.sv
`timescale 1ns/1ps
module pip_capture_wr
  import pip_pkg::*;
#(
  parameter int PIX_W          = 8,
  parameter int Q_W            = 7,
  parameter int LUMA_PIX       = 21,
  parameter int CHROMA_PIX     = 5,
  parameter int ROWS_NINTH     = 7,
  parameter int ROWS_SIXTEENTH = 5,
  localparam int LUMA_DEPTH    = LUMA_PIX * ROWS_NINTH,
  localparam int CHROMA_DEPTH  = CHROMA_PIX * ROWS_NINTH,
  localparam int LA_W          = $clog2(LUMA_DEPTH),
  localparam int CA_W          = $clog2(CHROMA_DEPTH),
  localparam int ROW_W         = $clog2(ROWS_NINTH + 1),
  localparam int COL_W         = $clog2(LUMA_PIX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pip_size_e           size,
  input  logic                freeze,
  input  logic                cap_valid,
  input  logic                cap_hsync,
  input  logic                cap_vsync,
  input  logic [PIX_W-1:0]    cap_y,
  input  logic [PIX_W-1:0]    cap_cb,
  input  logic [PIX_W-1:0]    cap_cr,
  output logic                luma_we,
  output logic [LA_W-1:0]     luma_waddr,
  output logic [Q_W-1:0]      luma_wdata,
  output logic                chroma_we,
  output logic [CA_W-1:0]     chroma_waddr,
  output logic [2*Q_W-1:0]    chroma_wdata
);
  logic [1:0]       lphase_q, lphase_d;
  logic [1:0]       xphase_q, xphase_d;
  logic [ROW_W-1:0] row_nxt_q, row_nxt_d;
  logic [ROW_W-1:0] row_cur_q, row_cur_d;
  logic [COL_W-1:0] xcnt_q, xcnt_d;
  logic             keep_q, keep_d;
  logic [1:0]       smax;
  int               rows;
  logic             take;

  assign smax = step_m1(size);
  assign rows = (size == SZ_QUARTER) ? ROWS_SIXTEENTH : ROWS_NINTH;

  always_comb begin
    lphase_d  = lphase_q;
    xphase_d  = xphase_q;
    row_nxt_d = row_nxt_q;
    row_cur_d = row_cur_q;
    xcnt_d    = xcnt_q;
    keep_d    = keep_q;
    if (cap_vsync) begin
      row_cur_d = '0;
      row_nxt_d = ROW_W'(1);
      keep_d    = 1'b1;
      lphase_d  = 2'd1;
      xcnt_d    = '0;
      xphase_d  = '0;
    end else if (cap_hsync) begin
      keep_d    = (lphase_q == 2'd0) && (int'(row_nxt_q) < rows);
      row_cur_d = row_nxt_q;
      lphase_d  = (lphase_q == smax) ? 2'd0 : lphase_q + 2'd1;
      if (lphase_q == 2'd0 && int'(row_nxt_q) < rows)
        row_nxt_d = row_nxt_q + ROW_W'(1);
      xcnt_d    = '0;
      xphase_d  = '0;
    end else if (cap_valid) begin
      xphase_d = (xphase_q == smax) ? 2'd0 : xphase_q + 2'd1;
      if (xphase_q == 2'd0 && int'(xcnt_q) < LUMA_PIX)
        xcnt_d = xcnt_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lphase_q  <= '0;
      xphase_q  <= '0;
      row_nxt_q <= '0;
      row_cur_q <= '0;
      xcnt_q    <= '0;
      keep_q    <= 1'b0;
    end else begin
      lphase_q  <= lphase_d;
      xphase_q  <= xphase_d;
      row_nxt_q <= row_nxt_d;
      row_cur_q <= row_cur_d;
      xcnt_q    <= xcnt_d;
      keep_q    <= keep_d;
    end
  end

  assign take = cap_valid && !cap_vsync && !cap_hsync && keep_q && !freeze &&
                (xphase_q == 2'd0) && (int'(xcnt_q) < LUMA_PIX);

  assign luma_we      = take;
  assign luma_waddr   = LA_W'(int'(row_cur_q) * LUMA_PIX + int'(xcnt_q));
  assign luma_wdata   = cap_y[PIX_W-1 -: Q_W];
  assign chroma_we    = take && (xcnt_q[1:0] == 2'b00) && ((int'(xcnt_q) / 4) < CHROMA_PIX);
  assign chroma_waddr = CA_W'(int'(row_cur_q) * CHROMA_PIX + int'(xcnt_q) / 4);
  assign chroma_wdata = {cap_cb[PIX_W-1 -: Q_W], cap_cr[PIX_W-1 -: Q_W]};

  // R12
  row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep_q |-> (int'(row_cur_q) < ROWS_NINTH));
  // R12
  col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> (int'(xcnt_q) <= LUMA_PIX));
endmodule

// File: rtl/pip_field_buf.sv
`timescale 1ns/1ps
module pip_field_buf #(
  parameter int Q_W          = 7,
  parameter int LUMA_DEPTH   = 147,
  parameter int CHROMA_DEPTH = 35,
  localparam int LA_W        = $clog2(LUMA_DEPTH),
  localparam int CA_W        = $clog2(CHROMA_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             luma_we,
  input  logic [LA_W-1:0]  luma_waddr,
  input  logic [Q_W-1:0]   luma_wdata,
  input  logic             chroma_we,
  input  logic [CA_W-1:0]  chroma_waddr,
  input  logic [2*Q_W-1:0] chroma_wdata,
  input  logic [LA_W-1:0]  luma_raddr,
  input  logic [CA_W-1:0]  chroma_raddr,
  output logic [Q_W-1:0]   luma_rdata,
  output logic [2*Q_W-1:0] chroma_rdata
);
  logic [Q_W-1:0]   luma_mem   [LUMA_DEPTH];
  logic [2*Q_W-1:0] chroma_mem [CHROMA_DEPTH];

  always_ff @(posedge clk) begin
    if (luma_we)   luma_mem[luma_waddr]     <= luma_wdata;
    if (chroma_we) chroma_mem[chroma_waddr] <= chroma_wdata;
  end

  assign luma_rdata   = luma_mem[luma_raddr];
  assign chroma_rdata = chroma_mem[chroma_raddr];

  // R4
  wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (luma_we |-> int'(luma_waddr) < LUMA_DEPTH) and
    (chroma_we |-> int'(chroma_waddr) < CHROMA_DEPTH));
  // R7
  rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(luma_raddr) < LUMA_DEPTH) && (int'(chroma_raddr) < CHROMA_DEPTH));
endmodule

// File: rtl/pip_display_rd.sv
`timescale 1ns/1ps
module pip_display_rd
  import pip_pkg::*;
#(
  parameter int PIX_W          = 8,
  parameter int Q_W            = 7,
  parameter int LUMA_PIX       = 21,
  parameter int CHROMA_PIX     = 5,
  parameter int ROWS_NINTH     = 7,
  parameter int ROWS_SIXTEENTH = 5,
  parameter int CRD_W          = 10,
  localparam int LUMA_DEPTH    = LUMA_PIX * ROWS_NINTH,
  localparam int CHROMA_DEPTH  = CHROMA_PIX * ROWS_NINTH,
  localparam int LA_W          = $clog2(LUMA_DEPTH),
  localparam int CA_W          = $clog2(CHROMA_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CRD_W-1:0]  sh_px,
  input  logic [CRD_W-1:0]  sh_py,
  input  pip_size_e         sh_size,
  input  logic              sh_bord_en,
  input  logic [PIX_W-1:0]  sh_bord_lvl,
  input  logic              disp_valid,
  input  logic              disp_hsync,
  input  logic              disp_vsync,
  input  logic [PIX_W-1:0]  main_y,
  input  logic [PIX_W-1:0]  main_cb,
  input  logic [PIX_W-1:0]  main_cr,
  output logic [LA_W-1:0]   luma_raddr,
  output logic [CA_W-1:0]   chroma_raddr,
  input  logic [Q_W-1:0]    luma_rdata,
  input  logic [2*Q_W-1:0]  chroma_rdata,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_y,
  output logic [PIX_W-1:0]  out_cb,
  output logic [PIX_W-1:0]  out_cr
);
  localparam logic [PIX_W-1:0] NEUTRAL = {1'b1, {(PIX_W-1){1'b0}}};
  localparam logic [CRD_W-1:0] CRD_MAX = '1;

  logic [CRD_W-1:0] hcnt_q, hcnt_d, vcnt_q, vcnt_d;
  logic [PIX_W-1:0] y_d, cb_d, cr_d;
  logic             in_win, on_border;
  int               h, v, px, py, rows, rx, ry, cidx;

  always_comb begin
    hcnt_d = hcnt_q;
    vcnt_d = vcnt_q;
    if (disp_vsync) begin
      hcnt_d = '0;
      vcnt_d = '0;
    end else if (disp_hsync) begin
      hcnt_d = '0;
      if (vcnt_q != CRD_MAX) vcnt_d = vcnt_q + CRD_W'(1);
    end else if (disp_valid && hcnt_q != CRD_MAX) begin
      hcnt_d = hcnt_q + CRD_W'(1);
    end
  end

  always_comb begin
    h    = int'(hcnt_q);
    v    = int'(vcnt_q);
    px   = int'(sh_px);
    py   = int'(sh_py);
    rows = (sh_size == SZ_QUARTER) ? ROWS_SIXTEENTH : ROWS_NINTH;
    in_win = (h >= px) && (h < px + LUMA_PIX) && (v >= py) && (v < py + rows);
    on_border = sh_bord_en && !in_win &&
                (h + 1 >= px) && (h <= px + LUMA_PIX) &&
                (v + 1 >= py) && (v <= py + rows);
    rx   = in_win ? h - px : 0;
    ry   = in_win ? v - py : 0;
    cidx = (rx / 4 > CHROMA_PIX - 1) ? CHROMA_PIX - 1 : rx / 4;
    luma_raddr   = LA_W'(ry * LUMA_PIX + rx);
    chroma_raddr = CA_W'(ry * CHROMA_PIX + cidx);
  end

  always_comb begin
    y_d  = main_y;
    cb_d = main_cb;
    cr_d = main_cr;
    if (enable && in_win) begin
      y_d  = {luma_rdata, {(PIX_W-Q_W){1'b0}}};
      cb_d = {chroma_rdata[2*Q_W-1:Q_W], {(PIX_W-Q_W){1'b0}}};
      cr_d = {chroma_rdata[Q_W-1:0], {(PIX_W-Q_W){1'b0}}};
    end else if (enable && on_border) begin
      y_d  = sh_bord_lvl;
      cb_d = NEUTRAL;
      cr_d = NEUTRAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q    <= '0;
      vcnt_q    <= '0;
      out_valid <= 1'b0;
      out_y     <= '0;
      out_cb    <= '0;
      out_cr    <= '0;
    end else begin
      hcnt_q    <= hcnt_d;
      vcnt_q    <= vcnt_d;
      out_valid <= disp_valid;
      if (disp_valid) begin
        out_y  <= y_d;
        out_cb <= cb_d;
        out_cr <= cr_d;
      end
    end
  end

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !enable) |=> (out_valid && out_y == $past(main_y) &&
                                 out_cb == $past(main_cb) && out_cr == $past(main_cr)));
  // R9
  border_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && enable && on_border) |=>
      (out_y == $past(sh_bord_lvl) && out_cb == NEUTRAL && out_cr == NEUTRAL));
  // R6
  inset_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && enable && in_win) |=> (out_y[0] == 1'b0));
endmodule

// File: rtl/pip_inset_compositor.sv
`timescale 1ns/1ps
module pip_inset_compositor
  import pip_pkg::*;
#(
  parameter int PIX_W          = 8,
  parameter int Q_W            = 7,
  parameter int LUMA_PIX       = 21,
  parameter int CHROMA_PIX     = 5,
  parameter int ROWS_NINTH     = 7,
  parameter int ROWS_SIXTEENTH = 5,
  parameter int CRD_W          = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_freeze,
  input  logic             cfg_size,
  input  logic             cfg_border_en,
  input  logic [PIX_W-1:0] cfg_border_lvl,
  input  logic [CRD_W-1:0] cfg_pos_x,
  input  logic [CRD_W-1:0] cfg_pos_y,
  input  logic             cap_valid,
  input  logic             cap_hsync,
  input  logic             cap_vsync,
  input  logic [PIX_W-1:0] cap_y,
  input  logic [PIX_W-1:0] cap_cb,
  input  logic [PIX_W-1:0] cap_cr,
  input  logic             disp_valid,
  input  logic             disp_hsync,
  input  logic             disp_vsync,
  input  logic [PIX_W-1:0] main_y,
  input  logic [PIX_W-1:0] main_cb,
  input  logic [PIX_W-1:0] main_cr,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_y,
  output logic [PIX_W-1:0] out_cb,
  output logic [PIX_W-1:0] out_cr
);
  localparam int LUMA_DEPTH   = LUMA_PIX * ROWS_NINTH;
  localparam int CHROMA_DEPTH = CHROMA_PIX * ROWS_NINTH;
  localparam int LA_W         = $clog2(LUMA_DEPTH);
  localparam int CA_W         = $clog2(CHROMA_DEPTH);

  logic [1:0]       rsync_q;
  logic             rst_sync_n;

  logic [CRD_W-1:0] sh_px_q, sh_px_d, sh_py_q, sh_py_d;
  pip_size_e        sh_size_q, sh_size_d;
  logic             sh_bord_en_q, sh_bord_en_d;
  logic [PIX_W-1:0] sh_bord_lvl_q, sh_bord_lvl_d;

  logic             luma_we, chroma_we;
  logic [LA_W-1:0]  luma_waddr, luma_raddr;
  logic [CA_W-1:0]  chroma_waddr, chroma_raddr;
  logic [Q_W-1:0]   luma_wdata, luma_rdata;
  logic [2*Q_W-1:0] chroma_wdata, chroma_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  always_comb begin
    sh_px_d       = sh_px_q;
    sh_py_d       = sh_py_q;
    sh_size_d     = sh_size_q;
    sh_bord_en_d  = sh_bord_en_q;
    sh_bord_lvl_d = sh_bord_lvl_q;
    if (disp_vsync) begin
      sh_px_d       = cfg_pos_x;
      sh_py_d       = cfg_pos_y;
      sh_size_d     = pip_size_e'(cfg_size);
      sh_bord_en_d  = cfg_border_en;
      sh_bord_lvl_d = cfg_border_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sh_px_q       <= '0;
      sh_py_q       <= '0;
      sh_size_q     <= SZ_THIRD;
      sh_bord_en_q  <= 1'b0;
      sh_bord_lvl_q <= '0;
    end else begin
      sh_px_q       <= sh_px_d;
      sh_py_q       <= sh_py_d;
      sh_size_q     <= sh_size_d;
      sh_bord_en_q  <= sh_bord_en_d;
      sh_bord_lvl_q <= sh_bord_lvl_d;
    end
  end

  pip_capture_wr #(
    .PIX_W(PIX_W), .Q_W(Q_W), .LUMA_PIX(LUMA_PIX), .CHROMA_PIX(CHROMA_PIX),
    .ROWS_NINTH(ROWS_NINTH), .ROWS_SIXTEENTH(ROWS_SIXTEENTH)
  ) cap_i (
    .clk(clk), .rst_n(rst_sync_n), .size(sh_size_q), .freeze(cfg_freeze),
    .cap_valid(cap_valid), .cap_hsync(cap_hsync), .cap_vsync(cap_vsync),
    .cap_y(cap_y), .cap_cb(cap_cb), .cap_cr(cap_cr),
    .luma_we(luma_we), .luma_waddr(luma_waddr), .luma_wdata(luma_wdata),
    .chroma_we(chroma_we), .chroma_waddr(chroma_waddr), .chroma_wdata(chroma_wdata)
  );

  pip_field_buf #(
    .Q_W(Q_W), .LUMA_DEPTH(LUMA_DEPTH), .CHROMA_DEPTH(CHROMA_DEPTH)
  ) buf_i (
    .clk(clk), .rst_n(rst_sync_n),
    .luma_we(luma_we), .luma_waddr(luma_waddr), .luma_wdata(luma_wdata),
    .chroma_we(chroma_we), .chroma_waddr(chroma_waddr), .chroma_wdata(chroma_wdata),
    .luma_raddr(luma_raddr), .chroma_raddr(chroma_raddr),
    .luma_rdata(luma_rdata), .chroma_rdata(chroma_rdata)
  );

  pip_display_rd #(
    .PIX_W(PIX_W), .Q_W(Q_W), .LUMA_PIX(LUMA_PIX), .CHROMA_PIX(CHROMA_PIX),
    .ROWS_NINTH(ROWS_NINTH), .ROWS_SIXTEENTH(ROWS_SIXTEENTH), .CRD_W(CRD_W)
  ) disp_i (
    .clk(clk), .rst_n(rst_sync_n), .enable(cfg_enable),
    .sh_px(sh_px_q), .sh_py(sh_py_q), .sh_size(sh_size_q),
    .sh_bord_en(sh_bord_en_q), .sh_bord_lvl(sh_bord_lvl_q),
    .disp_valid(disp_valid), .disp_hsync(disp_hsync), .disp_vsync(disp_vsync),
    .main_y(main_y), .main_cb(main_cb), .main_cr(main_cr),
    .luma_raddr(luma_raddr), .chroma_raddr(chroma_raddr),
    .luma_rdata(luma_rdata), .chroma_rdata(chroma_rdata),
    .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );

  // R11
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !disp_vsync |=> ($stable(sh_px_q) && $stable(sh_py_q) && $stable(sh_size_q) &&
                     $stable(sh_bord_en_q) && $stable(sh_bord_lvl_q)));
  // R10
  freeze_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_freeze |-> (!luma_we && !chroma_we));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && out_y == '0 && out_cb == '0 && out_cr == '0));
endmodule

// File: tb/pip_inset_compositor_tb_top.sv
`timescale 1ns/1ps
module pip_inset_compositor_tb_top;
  localparam int LPIX = 21;
  localparam int CPIX = 5;
  localparam int R9N  = 7;
  localparam int R16N = 5;
  localparam int FW   = 40;
  localparam int FH   = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0, cfg_freeze = 1'b0, cfg_size = 1'b0, cfg_border_en = 1'b0;
  logic [7:0] cfg_border_lvl = '0;
  logic [9:0] cfg_pos_x = '0, cfg_pos_y = '0;
  logic       cap_valid = 1'b0, cap_hsync = 1'b0, cap_vsync = 1'b0;
  logic [7:0] cap_y = '0, cap_cb = '0, cap_cr = '0;
  logic       disp_valid = 1'b0, disp_hsync = 1'b0, disp_vsync = 1'b0;
  logic [7:0] main_y = '0, main_cb = '0, main_cr = '0;
  logic       out_valid;
  logic [7:0] out_y, out_cb, out_cr;

  int n_run = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  // model of the applied settings and stored field
  int e_px, e_py, e_size, e_bord, e_lvl;
  int st_seed, st_step;

  always #5 clk = ~clk;

  pip_inset_compositor dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_freeze(cfg_freeze),
    .cfg_size(cfg_size), .cfg_border_en(cfg_border_en), .cfg_border_lvl(cfg_border_lvl),
    .cfg_pos_x(cfg_pos_x), .cfg_pos_y(cfg_pos_y),
    .cap_valid(cap_valid), .cap_hsync(cap_hsync), .cap_vsync(cap_vsync),
    .cap_y(cap_y), .cap_cb(cap_cb), .cap_cr(cap_cr),
    .disp_valid(disp_valid), .disp_hsync(disp_hsync), .disp_vsync(disp_vsync),
    .main_y(main_y), .main_cb(main_cb), .main_cr(main_cr),
    .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );

  function automatic int yin(int s, int l, int p);  return (s + l*7 + p*3) & 255; endfunction
  function automatic int cbin(int s, int l, int p); return (s*3 + l*5 + p) & 255; endfunction
  function automatic int crin(int s, int l, int p); return (s + 255 - l - 2*p) & 255; endfunction
  function automatic int my(int h, int v);  return (h*5 + v*11) & 255; endfunction
  function automatic int mcb(int h, int v); return (h + 3*v + 17) & 255; endfunction
  function automatic int mcr(int h, int v); return (200 - h + v) & 255; endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  task automatic pulse_dvsync();
    @(negedge clk); disp_valid = 0; disp_vsync = 1;
    @(negedge clk); disp_vsync = 0;
    e_px = int'(cfg_pos_x); e_py = int'(cfg_pos_y); e_size = int'(cfg_size);
    e_bord = int'(cfg_border_en); e_lvl = int'(cfg_border_lvl);
  endtask

  task automatic disp_lines(string tag);
    for (int v = 0; v < FH; v++) begin
      if (v > 0) begin
        @(negedge clk); disp_valid = 0; disp_hsync = 1;
        @(negedge clk); disp_hsync = 0;
      end
      for (int h = 0; h < FW; h++) begin
        int step, rows, ey, ecb, ecr, r, x, c;
        bit ins, brd;
        @(negedge clk);
        disp_valid = 1;
        main_y = 8'(my(h, v)); main_cb = 8'(mcb(h, v)); main_cr = 8'(mcr(h, v));
        @(posedge clk); #2;
        step = st_step;
        rows = e_size ? R16N : R9N;
        ins = (h >= e_px) && (h < e_px + LPIX) && (v >= e_py) && (v < e_py + rows);
        brd = (e_bord != 0) && !ins && (h + 1 >= e_px) && (h <= e_px + LPIX) &&
              (v + 1 >= e_py) && (v <= e_py + rows);
        ey = my(h, v); ecb = mcb(h, v); ecr = mcr(h, v);
        if (!cfg_enable) begin
          chk("R2 y", int'(out_y), ey); chk("R2 cb", int'(out_cb), ecb);
          chk("R2 cr", int'(out_cr), ecr); chk("R2 valid", int'(out_valid), 1);
        end else if (ins) begin
          r = v - e_py; x = h - e_px;
          c = (x / 4 > CPIX - 1) ? CPIX - 1 : x / 4;
          chk(tag, int'(out_y), yin(st_seed, step*r, step*x) & 254);
          chk("R6 lsb", int'(out_y[0]), 0);
          chk("R7 cb", int'(out_cb), cbin(st_seed, step*r, step*4*c) & 254);
          chk("R7 cr", int'(out_cr), crin(st_seed, step*r, step*4*c) & 254);
        end else if (brd) begin
          chk("R9 y", int'(out_y), e_lvl); chk("R9 cb", int'(out_cb), 128);
          chk("R9 cr", int'(out_cr), 128);
        end else begin
          chk("R3 y", int'(out_y), ey); chk("R3 cb", int'(out_cb), ecb);
          chk("R3 cr", int'(out_cr), ecr);
        end
      end
    end
    @(negedge clk); disp_valid = 0;
  endtask

  task automatic disp_frame(string tag);
    pulse_dvsync();
    disp_lines(tag);
  endtask

  // capture a field; lines and samples run past the stored area (R12)
  task automatic capture(int seed);
    @(negedge clk); cap_valid = 0; cap_vsync = 1;
    @(negedge clk); cap_vsync = 0;
    for (int l = 0; l < 3*R9N + 2; l++) begin
      if (l > 0) begin
        @(negedge clk); cap_valid = 0; cap_hsync = 1;
        @(negedge clk); cap_hsync = 0;
      end
      for (int p = 0; p < 4*LPIX + 3; p++) begin
        if (p % 5 == 4) begin
          @(negedge clk); cap_valid = 0;
          cap_y = 8'hFF; cap_cb = 8'hFF; cap_cr = 8'hFF;
        end
        @(negedge clk);
        cap_valid = 1;
        cap_y = 8'(yin(seed, l, p)); cap_cb = 8'(cbin(seed, l, p)); cap_cr = 8'(crin(seed, l, p));
      end
    end
    @(negedge clk); cap_valid = 0;
    if (!cfg_freeze) begin
      st_seed = seed;
      st_step = e_size ? 4 : 3;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R1 valid", int'(out_valid), 0); chk("R1 y", int'(out_y), 0);
    chk("R1 cb", int'(out_cb), 0);       chk("R1 cr", int'(out_cr), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    chk("R1 valid after release", int'(out_valid), 0);
    chk("R1 y after release", int'(out_y), 0);
    repeat (3) @(negedge clk);

    // R4, R12: one-third size, border on
    cfg_enable = 1; cfg_size = 0; cfg_pos_x = 10'd5; cfg_pos_y = 10'd4;
    cfg_border_en = 1; cfg_border_lvl = 8'd200;
    pulse_dvsync();
    capture(10);
    disp_frame("R4 R12 y");

    // R8: move the inset
    cfg_pos_x = 10'd12; cfg_pos_y = 10'd6; cfg_border_lvl = 8'd37;
    disp_frame("R8 y");

    // R11: change after vsync has no effect until the next vsync
    pulse_dvsync();
    cfg_pos_x = 10'd0; cfg_pos_y = 10'd0; cfg_size = 1; cfg_border_en = 0;
    disp_lines("R11 y");

    // R5: one-quarter size at origin, border off (R3 on ring)
    pulse_dvsync();
    capture(77);
    disp_frame("R5 y");

    // R9: border at origin, only right and bottom visible
    cfg_border_en = 1; cfg_border_lvl = 8'd235;
    disp_frame("R9 inset y");

    // R10: freeze keeps old field
    cfg_freeze = 1;
    capture(150);
    cfg_freeze = 0;
    disp_frame("R10 y");

    // R2: overlay disabled
    cfg_enable = 0;
    disp_frame("R2 inset y");

    done = 1;
    report();
  end
endmodule